// File: doc/BRIEF.md
# IPv4 Destination Address Matcher

This block listens to a packet stream that moves eight bytes per clock. Each packet starts with an 8-byte internal shim. After that come a 14-byte Ethernet header and a 20-byte IPv4 header without options. Counting from the start of the packet, the 32-bit IPv4 destination address sits at bytes 38 to 41. That span crosses a word boundary:

- The upper half is the low 16 bits of word 4.
- The lower half is the high 16 bits of word 5.

The block counts the accepted words of each packet and saves the upper half when word 4 goes by. It joins that half to the lower half when word 5 arrives. It then presents the full address for one cycle with a strobe, and it also flags whether the address equals a target. The target is a parameter and defaults to 141.142.2.2 (0x8D8E0202). The block never changes the stream. It only watches the stream and can sit beside any pipeline stage.

A small state machine tracks the word position. Its states are:

- ST_IDLE: no packet has started since reset.
- ST_COUNT: words 1 to 4 are being counted.
- ST_LOWER: the next accepted word is word 5.
- ST_HOLD: the address of this packet has been taken, and the rest of the packet is ignored.

Its transitions are:

- Any state goes to ST_COUNT on an accepted start-of-packet word, with the next expected position set to 1.
- ST_COUNT moves to ST_LOWER when word 4 is accepted. The upper half is taken on that same beat.
- ST_COUNT stays in ST_COUNT and advances the position on words 1 to 3.
- ST_LOWER moves to ST_HOLD when word 5 is accepted. The lower half is taken and the strobe is scheduled on that same beat.
- ST_IDLE and ST_HOLD stay where they are on every other accepted word.
- Cycles with valid low cause no transition in any state.

Top module: `ipv4_dst_match`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, addr_valid and addr_match are 0 and dst_addr is 0.
- R2: A word with in_valid=1 and in_sop=1 is word 0 of a packet. Each later word with in_valid=1 and in_sop=0 is the next word position.
- R3: dst_addr[31:16] equals in_data[15:0] of word 4 of the packet.
- R4: dst_addr[15:0] equals in_data[63:48] of word 5. The new dst_addr appears in the cycle after word 5 is accepted and holds until the next packet's word 5.
- R5: addr_valid is high for exactly one cycle, the cycle after word 5 is accepted, and only once per packet. Words 6 and later raise no further strobe.
- R6: addr_match is 1 in that strobe cycle if and only if the assembled address equals TARGET (default 0x8D8E0202). It is 0 in every other cycle.
- R7: Cycles with in_valid=0 do not advance the word position, and their in_data is ignored.
- R8: An accepted start-of-packet word restarts the count. A packet that is cut short by a new start before its word 5 produces no strobe and no match.
- R9: in_sop asserted while in_valid=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Stream word; byte 0 in bits 63:56 |
| in_valid | input | 1 | in_data holds a word in this cycle |
| in_sop | input | 1 | The current word is word 0 of a packet |
| dst_addr | output | 32 | Last assembled destination address |
| addr_valid | output | 1 | One-cycle strobe: dst_addr was just updated |
| addr_match | output | 1 | dst_addr equals TARGET, in the strobe cycle |

## Verification
Each result is registered once. addr_valid, addr_match and the new dst_addr are all due in the cycle right after the edge that accepts word 5, and addr_valid must be low in every other cycle. The bench drives inputs on the falling edge. On each falling edge it first samples the outputs produced by the previous rising edge. It compares them with a pending flag that was set only when the previous beat carried word 5, so each check lands on the exact cycle the result is due. The bench sweeps the target address and every single-bit neighbour of it, moves stall gaps to every word position, truncates packets at every length below six words, and runs longer packets.

// File: rtl/ipdm_pkg.sv
package ipdm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_LOWER,
        ST_HOLD
    } trk_state_t;
endpackage

// File: rtl/ipdm_tracker.sv
module ipdm_tracker
    import ipdm_pkg::*;
#(
    parameter int HI_WORD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    output logic take_hi,
    output logic take_lo
);
    localparam int POS_W = $clog2(HI_WORD + 1) + 1;

    trk_state_t       state_q, state_n;
    logic [POS_W-1:0] pos_q, pos_n;
    logic             start, beat;

    assign start = in_valid && in_sop;
    assign beat  = in_valid && !in_sop;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        if (start) begin
            state_n = ST_COUNT;
            pos_n   = POS_W'(1);
        end else if (beat) begin
            unique case (state_q)
                ST_IDLE:  state_n = ST_IDLE;
                ST_COUNT: begin
                    if (pos_q == POS_W'(HI_WORD)) state_n = ST_LOWER;
                    else                          pos_n   = pos_q + POS_W'(1);
                end
                ST_LOWER: state_n = ST_HOLD;
                ST_HOLD:  state_n = ST_HOLD;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        take_hi = beat && (state_q == ST_COUNT) && (pos_q == POS_W'(HI_WORD));
        take_lo = beat && (state_q == ST_LOWER);
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pos_q) && $stable(state_q)));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_COUNT && pos_q == POS_W'(1)));

    // R2
    take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_hi && take_lo));
endmodule

// File: rtl/ipdm_capture.sv
module ipdm_capture #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take_hi,
    input  logic              take_lo,
    output logic [ADDR_W-1:0] cand_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              addr_valid
);
    localparam int HALF_W = ADDR_W / 2;

    logic [HALF_W-1:0] hi_q;

    assign cand_addr = {hi_q, in_data[DATA_W-1 -: HALF_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q       <= '0;
            dst_addr   <= '0;
            addr_valid <= 1'b0;
        end else begin
            if (take_hi) hi_q <= in_data[HALF_W-1:0];
            if (take_lo) dst_addr <= cand_addr;
            addr_valid <= take_lo;
        end
    end

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> $stable(dst_addr));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> !addr_valid);
endmodule

// File: rtl/ipdm_compare.sv
module ipdm_compare #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] TARGET = 32'h8D8E0202
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_lo,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic              addr_match
);
    always_ff @(posedge clk) begin
        if (!rst_n) addr_match <= 1'b0;
        else        addr_match <= take_lo && (cand_addr == ADDR_W'(TARGET));
    end
endmodule

// File: rtl/ipv4_dst_match.sv
module ipv4_dst_match #(
    parameter int          DATA_W  = 64,
    parameter int          ADDR_W  = 32,
    parameter int          HI_WORD = 4,
    parameter logic [31:0] TARGET  = 32'h8D8E0202
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_sop,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              addr_valid,
    output logic              addr_match
);
    logic              take_hi, take_lo;
    logic [ADDR_W-1:0] cand_addr;

    ipdm_tracker #(.HI_WORD(HI_WORD)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .take_hi(take_hi), .take_lo(take_lo)
    );

    ipdm_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .in_data(in_data),
        .take_hi(take_hi), .take_lo(take_lo), .cand_addr(cand_addr),
        .dst_addr(dst_addr), .addr_valid(addr_valid)
    );

    ipdm_compare #(.ADDR_W(ADDR_W), .TARGET(TARGET)) u_cmp (
        .clk(clk), .rst_n(rst_n), .take_lo(take_lo),
        .cand_addr(cand_addr), .addr_match(addr_match)
    );

    // R6
    match_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> addr_valid);

    // R6
    match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> (dst_addr == ADDR_W'(TARGET)));

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ($past(in_valid) && !$past(in_sop)));
endmodule

// File: tb/tb_ipv4_dst_match.sv
`timescale 1ns/1ps
module tb_ipv4_dst_match;
    localparam logic [31:0] TGT = 32'h8D8E0202;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [31:0] dst_addr;
    logic        addr_valid, addr_match;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit pend = 1'b0;
    logic [31:0] exp_addr = '0;
    logic [31:0] held_addr = '0;

    always #2.5 clk = ~clk;

    ipv4_dst_match dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .dst_addr(dst_addr), .addr_valid(addr_valid),
        .addr_match(addr_match)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample last edge's result, then drive the next beat.
    task automatic beat(input logic [63:0] d, input logic v, input logic s, input bit is_w5);
        @(negedge clk);
        chk(addr_valid == pend, "R5 strobe", {63'd0, addr_valid}, {63'd0, pend});
        if (pend) begin
            chk(dst_addr == exp_addr, "R3 R4 address", {32'd0, dst_addr}, {32'd0, exp_addr});
            chk(addr_match == (exp_addr == TGT), "R6 match", {63'd0, addr_match}, {63'd0, exp_addr == TGT});
            held_addr = exp_addr;
        end else begin
            chk(addr_match == 1'b0, "R6 match off", {63'd0, addr_match}, 64'd0);
            chk(dst_addr == held_addr, "R4 hold", {32'd0, dst_addr}, {32'd0, held_addr});
        end
        pend = is_w5;
        in_data = d; in_valid = v; in_sop = s;
    endtask

    function automatic logic [63:0] fill(input int i, input int seed);
        logic [31:0] a;
        a = 32'h9E3779B9 * (seed + 1) + 32'h1234567 * (i + 3);
        return {a, ~a ^ 32'h5A5A0F0F};
    endfunction

    // Send n words; gap_len stall beats before word gap_at (sop raised on odd stalls, R9).
    task automatic pkt(input logic [31:0] addr, input int n, input int gap_at, input int gap_len, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [63:0] w;
            if (i == gap_at)
                for (int g = 0; g < gap_len; g++)
                    beat(~fill(i + g, seed), 1'b0, g[0], 1'b0); // R7 R9
            w = fill(i, seed);
            if (i == 4) w[15:0] = addr[31:16];
            if (i == 5) begin
                w[63:48] = addr[15:0];
                exp_addr = addr;
            end
            beat(w, 1'b1, i == 0, i == 5);
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            // R1
            chk(!addr_valid && !addr_match && dst_addr == 0, "R1 reset", {31'd0, addr_valid, addr_match, dst_addr}, 64'd0);
        end
        rst_n = 1'b1;
        // R2 R3 R4 R5 R6 R7: target and all single-bit neighbours, gaps moved around
        for (int b = -1; b < 32; b++) begin
            logic [31:0] a;
            a = (b < 0) ? TGT : (TGT ^ (32'd1 << b));
            pkt(a, 6 + (b & 3), (b + 7) % 7, (b + 1) % 4, b + 5);
            for (int t = 0; t < (b % 2); t++) beat('0, 1'b0, 1'b0, 1'b0);
        end
        // R8: truncated packets, then a complete one
        for (int n = 1; n < 6; n++) begin
            pkt(TGT, n, 9, 0, n);
            pkt(32'h0A000001 + n, 6, 9, 0, n + 40);
        end
        // R8: cut after word 4 by a new start carrying the target
        pkt(32'hC0A80101, 5, 9, 0, 77);
        pkt(TGT, 7, 5, 2, 78);
        // R9: sop with valid low mid-packet does not restart
        pkt(TGT, 3, 9, 0, 80);
        beat('1, 1'b0, 1'b1, 1'b0);
        for (int i = 3; i < 6; i++) begin
            logic [63:0] w;
            w = fill(i, 80);
            if (i == 4) w[15:0] = 16'h8D8E;
            if (i == 5) begin w[63:48] = 16'h0202; exp_addr = TGT; end
            beat(w, 1'b1, 1'b0, i == 5);
        end
        for (int t = 0; t < 4; t++) beat('0, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule